// File: doc/BRIEF.md
# SPI Transmit Queue Writer with Sticky Control

This block is the write side of an SPI transmit path. A register bus writes either to a data address or to a control-only address. The block keeps a sticky set of 12 per-transfer control bits, and it queues every data write as a data and control pair in an 8-entry transmit FIFO. An SPI shifter drains the FIFO through a valid/ready pop port. Each popped entry carries its own copy of the control bits, so a new control setting reaches the SPI side only after some data has been pushed with it.

The FIFO fill level is reported at a port. A service request is raised while the level is at or below a programmable threshold, which lets a CPU or DMA engine refill several entries for each request. A push to a full FIFO is discarded and sets a sticky overflow flag. Software clears that flag by writing one. The register is write-only, so its read data is always zero.

Top module: `spi_txq_writer`

## Requirements
- R1: After reset the FIFO is empty (fill_level 0, pop_valid 0), ovf_flag is clear and the latched control is all zeros, so the first pushed entry carries control 0.
- R2: A byte write (bus_size 0) to the data address pushes bus_wdata[7:0], zero-extended to 16 bits, together with the latched control. The upper halfword is ignored.
- R3: A halfword write (bus_size 1) to the data address pushes bus_wdata[15:0] with the latched control. The upper halfword is ignored.
- R4: A word write (bus_size 2 or 3) to the data address whose bus_wdata[31:16] is zero pushes bus_wdata[15:0] with the latched control and leaves that control unchanged.
- R5: A word write to the data address whose bus_wdata[31:16] is non-zero replaces the latched control with bus_wdata[27:16] and pushes the data with that new control in the same cycle. The new value stays latched for later pushes.
- R6: A write to the control-only address (bus_ctrl_sel 1) never pushes. A non-zero bus_wdata[31:16] replaces the latched control with bus_wdata[27:16]. A zero upper halfword changes nothing.
- R7: Entries leave in push order. pop_data and pop_ctrl come from the same entry. An entry is removed on a cycle with pop_valid and pop_ready both high, and the head holds steady while pop_ready is low.
- R8: fill_level counts the stored entries, from 0 to 8, one cycle after the push or pop. A push and a pop in the same cycle leave it unchanged.
- R9: tx_req is high exactly while fill_level is at or below thr_level.
- R10: A push while the FIFO holds 8 entries is dropped, even if a pop happens in the same cycle. The drop sets ovf_flag, which stays set until an ovf_clr pulse (a set in the same cycle wins). The latched control still updates on the dropped write.
- R11: bus_rdata is zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_ctrl_sel | input | 1 | 1 selects the control-only address, 0 the data address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata | input | 32 | Write data; [15:0] data, [27:16] control |
| bus_rdata | output | 32 | Read data, always zero |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| thr_level | input | 4 | Service request threshold |
| pop_valid | output | 1 | FIFO head is valid |
| pop_ready | input | 1 | Shifter accepts the head |
| pop_data | output | 16 | Head data |
| pop_ctrl | output | 12 | Head control bits |
| fill_level | output | 4 | Stored entry count |
| tx_req | output | 1 | Refill request |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong latched control stays hidden until the next push reaches the head of the queue. The bench therefore pops every directed entry and compares pop_ctrl, which also exposes a control update that is lost on a dropped or control-only write. Pointer or count faults show on fill_level, tx_req or the head data one cycle after the push or pop that caused them. A random phase with a reference queue compares all outputs on every cycle, so a fault caught there shows within a single cycle of reaching the ports.

// File: rtl/spi_txq_writer.sv
module spi_txq_writer #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int CW    = 12,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_ctrl_sel,
  input  logic [1:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ovf_clr,
  input  logic [LW-1:0] thr_level,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] pop_ctrl,
  output logic [LW-1:0] fill_level,
  output logic          tx_req,
  output logic          ovf_flag
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DW + CW;
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [CW-1:0] ctrl_q;
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;
  logic          ovf_q;

  wire           upper_nz = |bus_wdata[31:16];
  wire           ctrl_upd = bus_wr && upper_nz && (bus_ctrl_sel || bus_size[1]);
  wire           push_req = bus_wr && !bus_ctrl_sel;
  wire [CW-1:0]  ctrl_nxt = ctrl_upd ? bus_wdata[16 +: CW] : ctrl_q;
  wire [DW-1:0]  push_dat = (bus_size == 2'd0) ? {{(DW-8){1'b0}}, bus_wdata[7:0]}
                                               : bus_wdata[DW-1:0];
  wire           full     = (count == FULL_CNT);
  wire           push_ok  = push_req && !full;
  wire           pop_fire = pop_valid && pop_ready;

  assign bus_rdata  = '0;
  assign pop_valid  = (count != '0);
  assign {pop_ctrl, pop_data} = mem[rd_ptr];
  assign fill_level = count;
  assign tx_req     = (count <= thr_level);
  assign ovf_flag   = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= {ctrl_nxt, push_dat};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok)  wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_fire) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ovf_q <= 1'b0;
    else if (push_req && full) ovf_q <= 1'b1;
    else if (ovf_clr)          ovf_q <= 1'b0;
  end

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && full |=> ovf_flag);

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && full && !pop_fire |=> fill_level == $past(fill_level));

  // R6
  ctrl_only_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_ctrl_sel && !pop_fire |=> fill_level == $past(fill_level));

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && !pop_ready |=> pop_valid && $stable(pop_data) && $stable(pop_ctrl));

  // R5
  word_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ctrl_sel && bus_size[1] && upper_nz && !pop_valid
      |=> pop_valid && pop_ctrl == $past(bus_wdata[16 +: CW]));
endmodule

// File: tb/spi_txq_writer_tb.sv
`timescale 1ns/1ps
module spi_txq_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_ctrl_sel, ovf_clr, pop_ready;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  thr_level, fill_level;
  logic        pop_valid, tx_req, ovf_flag;
  logic [15:0] pop_data;
  logic [11:0] pop_ctrl;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [27:0] q[$];
  logic [11:0] m_ctrl;
  bit          m_ovf;
  int          m_thr;

  always #5 clk = ~clk;

  spi_txq_writer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_ctrl_sel(bus_ctrl_sel),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_clr(ovf_clr), .thr_level(thr_level), .pop_valid(pop_valid),
    .pop_ready(pop_ready), .pop_data(pop_data), .pop_ctrl(pop_ctrl),
    .fill_level(fill_level), .tx_req(tx_req), .ovf_flag(ovf_flag));

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk("R8 fill_level", fill_level, q.size());
    chk("R7 pop_valid", pop_valid, q.size() != 0);
    if (q.size() != 0) begin
      chk({tag, " head data"}, pop_data, q[0][15:0]);
      chk({tag, " head ctrl"}, pop_ctrl, q[0][27:16]);
    end
    chk("R9 tx_req", tx_req, q.size() <= m_thr);
    chk("R10 ovf_flag", ovf_flag, m_ovf);
    chk("R11 bus_rdata", bus_rdata, 0);
  endtask

  function automatic logic [11:0] exp_ctrl(bit wr, bit csel, logic [1:0] sz,
                                           logic [31:0] wd, logic [11:0] cur);
    if (wr && (wd[31:16] != 0) && (csel || sz[1])) return wd[27:16];
    return cur;
  endfunction

  function automatic logic [15:0] exp_data(logic [1:0] sz, logic [31:0] wd);
    return (sz == 2'd0) ? {8'h00, wd[7:0]} : wd[15:0];
  endfunction

  task automatic cyc(bit wr, bit csel, logic [1:0] sz, logic [31:0] wd,
                     bit rdy, bit clr, int thr, string tag);
    bit pop  = rdy && (q.size() != 0);
    bit push = wr && !csel;
    bit full = (q.size() == 8);
    logic [11:0] nc = exp_ctrl(wr, csel, sz, wd, m_ctrl);
    bus_wr = wr; bus_ctrl_sel = csel; bus_size = sz; bus_wdata = wd;
    pop_ready = rdy; ovf_clr = clr; thr_level = 4'(thr);
    if (pop) void'(q.pop_front());
    if (push && !full) q.push_back({nc, exp_data(sz, wd)});
    if (push && full) m_ovf = 1;
    else if (clr) m_ovf = 0;
    m_ctrl = nc;
    m_thr = thr;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_pop(string tag);
    cyc(0, 0, 2'd0, 32'h0, 1, 0, m_thr, tag);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] seed;
    rst_n = 0; bus_wr = 0; bus_ctrl_sel = 0; bus_size = 0; bus_wdata = 0;
    ovf_clr = 0; pop_ready = 0; thr_level = 4'd7;
    m_ctrl = 0; m_ovf = 0; m_thr = 7;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset fill_level", fill_level, 0);
    chk("R1 reset pop_valid", pop_valid, 0);
    chk("R1 reset ovf_flag", ovf_flag, 0);
    chk("R1 reset tx_req", tx_req, 1);

    cyc(1, 0, 2'd1, 32'h0000_1234, 0, 0, 7, "R1");
    chk("R1 reset ctrl zero", pop_ctrl, 0);
    idle_pop("R7");

    cyc(1, 0, 2'd0, 32'h5A5A_C3A7, 0, 0, 7, "R2");
    chk("R2 byte zero-extended", pop_data, 16'h00A7);
    chk("R2 upper ignored", pop_ctrl, 0);
    idle_pop("R7");

    cyc(1, 1, 2'd1, 32'h0ABC_0000, 0, 0, 7, "R6");
    chk("R6 ctrl-only no push", fill_level, 0);
    cyc(1, 0, 2'd1, 32'h9999_BEEF, 0, 0, 7, "R3");
    chk("R3 half data", pop_data, 16'hBEEF);
    chk("R3 latched ctrl", pop_ctrl, 12'hABC);
    idle_pop("R7");

    cyc(1, 1, 2'd1, 32'h0000_FFFF, 0, 0, 7, "R6");
    chk("R6 zero ctrl-only no push", fill_level, 0);
    cyc(1, 0, 2'd2, 32'h0000_4321, 0, 0, 7, "R4");
    chk("R4 ctrl kept", pop_ctrl, 12'hABC);
    chk("R4 data", pop_data, 16'h4321);
    idle_pop("R7");

    cyc(1, 0, 2'd2, 32'h0123_7777, 0, 0, 7, "R5");
    chk("R5 new ctrl on entry", pop_ctrl, 12'h123);
    cyc(1, 0, 2'd0, 32'h0000_0011, 0, 0, 7, "R5");
    idle_pop("R5");
    chk("R5 ctrl sticks", pop_ctrl, 12'h123);
    chk("R5 second data", pop_data, 16'h0011);
    idle_pop("R7");

    for (int i = 0; i < 8; i++) cyc(1, 0, 2'd1, 32'h0000_0100 + i, 0, 0, 7, "R7");
    chk("R8 full level", fill_level, 8);
    chk("R9 req low when full", tx_req, 0);
    cyc(1, 0, 2'd2, 32'h0FED_0001, 1, 0, 7, "R10");
    chk("R10 dropped with pop", fill_level, 7);
    chk("R10 ovf set", ovf_flag, 1);
    for (int i = 1; i < 8; i++) begin
      chk("R7 order", pop_data, 16'h0100 + i);
      idle_pop("R7");
    end
    cyc(1, 0, 2'd0, 32'h0000_0055, 0, 0, 7, "R10");
    chk("R10 ctrl updated on drop", pop_ctrl, 12'hFED);
    cyc(1, 0, 2'd1, 32'h0000_0066, 1, 0, 7, "R8");
    chk("R8 push+pop same level", fill_level, 1);
    cyc(0, 0, 2'd0, 32'h0, 0, 1, 7, "R10");
    chk("R10 ovf cleared", ovf_flag, 0);
    cyc(1, 0, 2'd1, 32'h0000_0077, 0, 0, 2, "R9");
    cyc(1, 0, 2'd1, 32'h0000_0088, 0, 0, 2, "R9");
    chk("R9 req low above thr", tx_req, 0);
    cyc(0, 0, 2'd0, 32'h0, 1, 0, 2, "R9");
    chk("R9 req high at thr", tx_req, 1);

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      int phase = (n / 500) % 2;
      bit wr = r < (phase ? 45 : 75);
      bit csel = ($urandom % 8) == 0;
      logic [1:0] sz = 2'($urandom % 4);
      logic [31:0] wd = $urandom;
      bit rdy = ($urandom % 100) < (phase ? 70 : 30);
      bit clr = ($urandom % 16) == 0;
      int thr = $urandom % 9;
      if (($urandom % 2) == 0) wd[31:16] = 16'h0;
      cyc(wr, csel, sz, wd, rdy, clr, thr, "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule